// File: doc/BRIEF.md
# Synchronous Serial Master with Register Bus

This block is a memory-mapped serial master that shifts frames of four to sixteen bits out on a data-out pin and in from a data-in pin, clocked by a bit clock it generates itself. Software programs it through a 32-bit register bus with a byte address and a combinational read path. One register sets the clock idle level, the sampling phase and the bit order. Another sets the frame length, written as the bit count minus three. A third holds the fractional divider that sets the bit rate. Write-only strobes switch the receiver, the transmitter and master operation on or off.

Behind the shift register there is a one-word transmit holding buffer and a one-word receive buffer. Writing a word to the transmit buffer starts a frame as soon as the engine is idle and operation is allowed. A second word written during a frame waits and follows straight after. Received words land in the receive buffer while the receiver is on. Two level-type event flags report free transmit space and valid received data. Software can set or clear each flag, and each flag drives its own interrupt line through an enable mask. A pin register enables the clock and data-out drivers, gates the data-in pin and selects one of eight pin locations. Chip selects are handled outside the block.

Top module: `sync_serial_master`

## Requirements
- R1: After reset every configuration register reads zero, the status register reads 0x40 (only bit 6 set), both interrupt lines are low and the bit clock output is low.
- R2: Offsets 0x00 (bits 0,8,9,10,12), 0x04 (bits 3:0), 0x14 (bits 21:0), 0x4C (bits 2:1) and 0x54 (bits 0,1,3,10:8) read back what was written, masked to those bits; 0x0C and 0x34 read as zero.
- R3: A frame starts only while offset 0x00 bit 0 is set, master operation has been enabled (0x0C bit 4) and the transmitter is enabled (0x0C bit 2 sets, bit 3 clears). Status bit 1 shows the transmitter enable. A word written while starting is not allowed stays held and status bit 6 stays low.
- R4: The frame length is the 0x04 field plus 3. A field below 1 gives 4 bits and a field above 13 gives 16 bits, so a frame always has twice that many clock transitions.
- R5: The bit clock idles at offset 0x00 bit 8. With bit 9 clear, data-in is sampled on the first transition of each bit and data-out changes on the second. With bit 9 set, data-out changes on the first and data-in is sampled on the second.
- R6: With offset 0x00 bit 10 set, the most significant bit goes first on both pins, otherwise the least significant. The received word is always right-aligned.
- R7: With divider value D at 0x14, every half period of the bit clock lasts floor or ceil of (256+D)/256 peripheral cycles, and exactly that when D is a multiple of 256 (D=0 gives half the peripheral clock rate).
- R8: The transmit buffer holds one word. Status bit 6 is high when it is empty. A word written during a frame is sent directly after that frame. Status bit 5 is set when a frame ends with the buffer empty and is cleared by a write to 0x34.
- R9: A finished frame is stored in the receive buffer only while the receiver is enabled (0x0C bit 0 sets, bit 1 clears). Status bit 7 shows valid data. A read of 0x18 returns the word in bits 15:0 and empties the buffer. A newer frame overwrites an unread word.
- R10: In the flag register 0x40, bit 1 is transmit space and bit 2 is received data. Hardware sets a flag every cycle its condition holds. Writing 1 to 0x44 sets a flag and writing 1 to 0x48 clears it, but the clear has no lasting effect while the condition holds.
- R11: Interrupt line irq_tx is flag bit 1 masked by 0x4C bit 1, and irq_rx is flag bit 2 masked by 0x4C bit 2.
- R12: In 0x54, bit 3 drives sclk_oe, bit 1 drives mosi_oe and bits 10:8 drive pin_loc. When bit 0 is clear, data-in is ignored and reads as zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| sclk_o | output | 1 | Bit clock |
| sclk_oe | output | 1 | Bit clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Data-out driver enable |
| miso_i | input | 1 | Serial data in |
| pin_loc | output | 3 | Selected pin location |
| irq_tx | output | 1 | Transmit-space interrupt |
| irq_rx | output | 1 | Received-data interrupt |

## Verification
The hardest case to reach is a second word written while a frame is still shifting, so that the holding buffer is full. The next frame must then start straight after the last transition of the first, and the unread receive word must be overwritten. The bench gets there with a large divider that stretches the first frame, and writes the second word on the following bus access. A bench-side decoder with data-out looped back to data-in rebuilds each frame from the pin transitions. It uses only the programmed phase, order and length, so the back-to-back frames, the clamped lengths and the random mode mixes are all checked at the pins.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
   localparam logic [7:0] OFS_MODE   = 8'h00;
   localparam logic [7:0] OFS_FLEN   = 8'h04;
   localparam logic [7:0] OFS_STROBE = 8'h0C;
   localparam logic [7:0] OFS_STAT   = 8'h10;
   localparam logic [7:0] OFS_DIV    = 8'h14;
   localparam logic [7:0] OFS_RXW    = 8'h18;
   localparam logic [7:0] OFS_TXW    = 8'h34;
   localparam logic [7:0] OFS_FLAG   = 8'h40;
   localparam logic [7:0] OFS_FSET   = 8'h44;
   localparam logic [7:0] OFS_FCLR   = 8'h48;
   localparam logic [7:0] OFS_MASK   = 8'h4C;
   localparam logic [7:0] OFS_PINS   = 8'h54;

   localparam int LEN_OFS = 3;

   typedef struct packed {
      logic lvl;
      logic msbf;
      logic cpha;
      logic cpol;
      logic sync;
   } mode_t;

   typedef struct packed {
      logic [2:0] loc;
      logic       clk_en;
      logic       out_en;
      logic       in_en;
   } pins_t;
endpackage

// File: rtl/ssm_baud.sv
module ssm_baud #(
   parameter int DIV_W  = 22,
   parameter int FRAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W:0] STEP = (DIV_W+1)'(1) << FRAC_W;

   logic [DIV_W:0] acc_q;

   assign tick = run && (acc_q >= {1'b0, div});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (!run)  acc_q <= '0;
      else if (tick)  acc_q <= acc_q - {1'b0, div};
      else            acc_q <= acc_q + STEP;
   end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] word,
   input  logic [CNT_W-1:0]  nbits,
   input  logic              cpha_i,
   input  logic              msbf_i,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sclk_int,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);
   logic [CNT_W-1:0]  nb_q;
   logic              cpha_q, msbf_q;
   logic [CNT_W:0]    k_q, last_k;
   logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt, low_mask;
   logic              at_last, samp, shft;

   assign last_k   = {nb_q, 1'b0} - 1'b1;
   assign at_last  = (k_q == last_k);
   assign done     = busy && tick && at_last;
   assign samp     = cpha_q ? k_q[0] : ~k_q[0];
   assign shft     = (cpha_q ? (~k_q[0] && (k_q != '0)) : k_q[0]) && !at_last;
   assign low_mask = {DATA_W{1'b1}} >> (CNT_W'(DATA_W) - nb_q);

   always_comb begin
      rx_nxt = rx_sh;
      if (samp)
         rx_nxt = msbf_q ? {rx_sh[DATA_W-2:0], miso} : {miso, rx_sh[DATA_W-1:1]};
   end

   assign rx_word = msbf_q ? (rx_nxt & low_mask) : (rx_nxt >> (CNT_W'(DATA_W) - nb_q));
   assign mosi    = msbf_q ? tx_sh[nb_q - 1'b1] : tx_sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; sclk_int <= 1'b0; k_q <= '0;
         tx_sh <= '0; rx_sh <= '0;
         nb_q <= CNT_W'(DATA_W); cpha_q <= 1'b0; msbf_q <= 1'b0;
      end else if (start) begin
         busy <= 1'b1; sclk_int <= 1'b0; k_q <= '0;
         tx_sh <= word; rx_sh <= '0;
         nb_q <= nbits; cpha_q <= cpha_i; msbf_q <= msbf_i;
      end else if (busy && tick) begin
         sclk_int <= ~sclk_int;
         k_q      <= k_q + 1'b1;
         rx_sh    <= rx_nxt;
         if (shft) tx_sh <= msbf_q ? (tx_sh << 1) : (tx_sh >> 1);
         if (at_last) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/ssm_flags.sv
module ssm_flags #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] hw,
   input  logic [NUM-1:0] set_v,
   input  logic [NUM-1:0] clr_v,
   input  logic [NUM-1:0] en,
   output logic [NUM-1:0] flags,
   output logic [NUM-1:0] irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= hw | set_v | (flags & ~clr_v);
   end

   for (genvar g = 0; g < NUM; g++) begin : g_line
      assign irq[g] = flags[g] & en[g];
   end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master #(
   parameter int DATA_W   = 16,
   parameter int MIN_BITS = 4,
   parameter int DIV_W    = 22,
   parameter int FRAC_W   = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        sclk_o,
   output logic        sclk_oe,
   output logic        mosi_o,
   output logic        mosi_oe,
   input  logic        miso_i,
   output logic [2:0]  pin_loc,
   output logic        irq_tx,
   output logic        irq_rx
);
   import ssm_pkg::*;

   localparam int CNT_W   = $clog2(DATA_W + 1);
   localparam int FLD_MIN = MIN_BITS - LEN_OFS;
   localparam int FLD_MAX = DATA_W - LEN_OFS;

   if (DATA_W < MIN_BITS || DATA_W > 16)
      $error("DATA_W must lie between MIN_BITS and 16");
   if (MIN_BITS < LEN_OFS + 1)
      $error("MIN_BITS too small for the length encoding");
   if (DIV_W <= FRAC_W || DIV_W > 30)
      $error("DIV_W must exceed FRAC_W and stay below 31");

   mode_t             mode_q;
   pins_t             pins_q;
   logic [3:0]        flen_q;
   logic [DIV_W-1:0]  div_q;
   logic [1:0]        mask_q;
   logic              rx_on, tx_on, mst_on;
   logic [DATA_W-1:0] txbuf, rxbuf;
   logic              txbuf_full, rxvalid, txc;

   logic              wr, rd, wr_tx, rd_rx, start, cap;
   logic [CNT_W-1:0]  nbits;
   logic              busy, tick, sclk_int, done, mosi_raw, miso_g;
   logic [DATA_W-1:0] rx_word;
   logic [1:0]        flags, irqs, set_v, clr_v;

   wire unused_wdata = ^bus_wdata[31:DIV_W];

   assign wr    = bus_sel & bus_we;
   assign rd    = bus_sel & ~bus_we;
   assign wr_tx = wr && (bus_addr == OFS_TXW);
   assign rd_rx = rd && (bus_addr == OFS_RXW);
   assign start = !busy && txbuf_full && tx_on && mst_on && mode_q.sync;
   assign cap   = done && rx_on;

   always_comb begin
      if (int'(flen_q) < FLD_MIN)      nbits = CNT_W'(MIN_BITS);
      else if (int'(flen_q) > FLD_MAX) nbits = CNT_W'(DATA_W);
      else                             nbits = CNT_W'(flen_q) + CNT_W'(LEN_OFS);
   end

   // configuration registers and command strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0; pins_q <= '0; flen_q <= '0; div_q <= '0; mask_q <= '0;
         rx_on <= 1'b0; tx_on <= 1'b0; mst_on <= 1'b0;
      end else if (wr) begin
         case (bus_addr)
            OFS_MODE: mode_q <= '{lvl: bus_wdata[12], msbf: bus_wdata[10],
                                  cpha: bus_wdata[9], cpol: bus_wdata[8], sync: bus_wdata[0]};
            OFS_FLEN: flen_q <= bus_wdata[3:0];
            OFS_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
            OFS_MASK: mask_q <= bus_wdata[2:1];
            OFS_PINS: pins_q <= '{loc: bus_wdata[10:8], clk_en: bus_wdata[3],
                                  out_en: bus_wdata[1], in_en: bus_wdata[0]};
            OFS_STROBE: begin
               if (bus_wdata[1])      rx_on <= 1'b0;
               else if (bus_wdata[0]) rx_on <= 1'b1;
               if (bus_wdata[3])      tx_on <= 1'b0;
               else if (bus_wdata[2]) tx_on <= 1'b1;
               if (bus_wdata[4])      mst_on <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // holding buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txbuf <= '0; txbuf_full <= 1'b0; txc <= 1'b0;
         rxbuf <= '0; rxvalid <= 1'b0;
      end else begin
         if (wr_tx) begin
            txbuf      <= bus_wdata[DATA_W-1:0];
            txbuf_full <= 1'b1;
            txc        <= 1'b0;
         end else begin
            if (start) txbuf_full <= 1'b0;
            if (done && !txbuf_full) txc <= 1'b1;
         end
         if (cap) begin
            rxbuf   <= rx_word;
            rxvalid <= 1'b1;
         end else if (rd_rx) begin
            rxvalid <= 1'b0;
         end
      end
   end

   ssm_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick));

   assign miso_g = miso_i & pins_q.in_en;

   ssm_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .word(txbuf), .nbits(nbits),
      .cpha_i(mode_q.cpha), .msbf_i(mode_q.msbf), .tick(tick), .miso(miso_g),
      .busy(busy), .sclk_int(sclk_int), .mosi(mosi_raw), .done(done), .rx_word(rx_word));

   assign set_v = (wr && bus_addr == OFS_FSET) ? bus_wdata[2:1] : 2'b00;
   assign clr_v = (wr && bus_addr == OFS_FCLR) ? bus_wdata[2:1] : 2'b00;

   ssm_flags #(.NUM(2)) u_flags (
      .clk(clk), .rst_n(rst_n), .hw({rxvalid, ~txbuf_full}), .set_v(set_v),
      .clr_v(clr_v), .en(mask_q), .flags(flags), .irq(irqs));

   assign irq_tx  = irqs[0];
   assign irq_rx  = irqs[1];
   assign sclk_o  = sclk_int ^ mode_q.cpol;
   assign mosi_o  = mosi_raw;
   assign sclk_oe = pins_q.clk_en;
   assign mosi_oe = pins_q.out_en;
   assign pin_loc = pins_q.loc;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_MODE: begin
            bus_rdata[0]  = mode_q.sync; bus_rdata[8]  = mode_q.cpol;
            bus_rdata[9]  = mode_q.cpha; bus_rdata[10] = mode_q.msbf;
            bus_rdata[12] = mode_q.lvl;
         end
         OFS_FLEN: bus_rdata[3:0] = flen_q;
         OFS_STAT: begin
            bus_rdata[1] = tx_on; bus_rdata[5] = txc;
            bus_rdata[6] = ~txbuf_full; bus_rdata[7] = rxvalid;
         end
         OFS_DIV:  bus_rdata[DIV_W-1:0] = div_q;
         OFS_RXW:  bus_rdata[DATA_W-1:0] = rxbuf;
         OFS_FLAG: bus_rdata[2:1] = flags;
         OFS_MASK: bus_rdata[2:1] = mask_q;
         OFS_PINS: begin
            bus_rdata[0] = pins_q.in_en; bus_rdata[1] = pins_q.out_en;
            bus_rdata[3] = pins_q.clk_en; bus_rdata[10:8] = pins_q.loc;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       tick,
   input logic       sclk_int,
   input logic       rd_rx,
   input logic       cap,
   input logic       rxvalid,
   input logic       txbuf_full,
   input logic [1:0] flags,
   input logic [1:0] mask_q,
   input logic       irq_tx,
   input logic       irq_rx
);
   a_r9_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !cap) |=> !rxvalid);
   a_r10_space_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !txbuf_full |=> flags[0]);
   a_r10_data_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rxvalid |=> flags[1]);
   a_r11_tx_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> mask_q[0]);
   a_r11_rx_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> mask_q[1]);
   a_r7_clock_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(sclk_int));
   a_r8_start_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(txbuf_full));
   a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_int);
endmodule

bind sync_serial_master ssm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick), .sclk_int(sclk_int),
   .rd_rx(rd_rx), .cap(cap), .rxvalid(rxvalid), .txbuf_full(txbuf_full),
   .flags(flags), .mask_q(mask_q), .irq_tx(irq_tx), .irq_rx(irq_rx));

// File: tb/test_sync_serial_master.sv
module test_sync_serial_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sclk_o, sclk_oe, mosi_o, mosi_oe, irq_tx, irq_rx;
   logic [2:0]  pin_loc;

   always #5 clk = ~clk;

   sync_serial_master i_sync_serial_master (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(mosi_o), .pin_loc(pin_loc), .irq_tx(irq_tx), .irq_rx(irq_rx));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_sel = 0;
   endtask

   // pin-level decoder
   bit clr_req = 0;
   logic prev_s = 1'b0;
   int tcount, nbit, cyc, iv_min, iv_max, nwords, exp_n = 8;
   bit m_cpha, m_msbf;
   logic [31:0] wacc;
   logic [31:0] words [4];

   always @(negedge clk) begin
      if (clr_req) begin
         tcount = 0; nbit = 0; cyc = 0; iv_min = 1000000; iv_max = 0;
         nwords = 0; wacc = 0; prev_s = sclk_o; clr_req = 0;
      end else begin
         cyc++;
         if (sclk_o !== prev_s) begin
            int tf;
            tcount++;
            tf = ((tcount - 1) % (2 * exp_n)) + 1;
            if (tf > 1) begin
               if (cyc < iv_min) iv_min = cyc;
               if (cyc > iv_max) iv_max = cyc;
            end
            if (m_cpha ? (tf % 2 == 0) : (tf % 2 == 1)) begin
               if (m_msbf) wacc = (wacc << 1) | 32'(mosi_o);
               else        wacc = wacc | (32'(mosi_o) << nbit);
               nbit++;
               if (nbit == exp_n) begin
                  if (nwords < 4) words[nwords] = wacc;
                  nwords++; wacc = 0; nbit = 0;
               end
            end
            cyc = 0;
            prev_s = sclk_o;
         end
      end
   end

   function automatic int len_of(input int fld);
      if (fld < 1) return 4;
      if (fld > 13) return 16;
      return fld + 3;
   endfunction

   function automatic logic [31:0] trim(input logic [31:0] d, input int n);
      return d & ((32'd1 << n) - 1);
   endfunction

   task automatic mon_clear();
      clr_req = 1;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(8'h10, s);
         if (s[5]) break;
      end
   endtask

   task automatic setup(input bit cp, input bit ph, input bit mf, input int fld, input int dv);
      wr(8'h00, 32'd1 | (32'(cp) << 8) | (32'(ph) << 9) | (32'(mf) << 10));
      wr(8'h04, 32'(fld));
      wr(8'h14, 32'(dv));
      m_cpha = ph; m_msbf = mf; exp_n = len_of(fld);
      mon_clear();
   endtask

   task automatic xfer(input bit cp, input bit ph, input bit mf, input int fld,
                       input int dv, input logic [31:0] data, input bit rxon);
      logic [31:0] r, ex;
      int n, lo, hi;
      wr(8'h0C, rxon ? 32'h15 : 32'h16);
      setup(cp, ph, mf, fld, dv);
      n = len_of(fld); ex = trim(data, n);
      lo = 1 + dv / 256; hi = lo + ((dv % 256) != 0 ? 1 : 0);
      wr(8'h34, data);
      wait_done();
      chk(tcount == 2 * n, "R4 transitions per frame", tcount, 2 * n);
      chk(nwords == 1 && words[0] == ex, "R5 R6 word on data-out", words[0], ex);
      chk(iv_min >= lo && iv_max <= hi, "R7 half period", iv_max, hi);
      chk(sclk_o == cp, "R5 idle level after frame", sclk_o, cp);
      rd(8'h10, r);
      chk(r[7] == rxon, "R9 valid follows receiver enable", r[7], rxon);
      if (rxon) begin
         rd(8'h40, r);
         chk(r[2], "R10 received-data flag", r, 32'h4);
         rd(8'h18, r);
         chk(r == ex, "R9 received word", r, ex);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, a, b;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(sclk_o == 0 && irq_tx == 0 && irq_rx == 0, "R1 outputs after reset",
          {sclk_o, irq_tx, irq_rx}, 0);
      rd(8'h10, r); chk(r == 32'h40, "R1 status after reset", r, 32'h40);
      rd(8'h00, r); chk(r == 0, "R1 mode after reset", r, 0);
      rd(8'h14, r); chk(r == 0, "R1 divider after reset", r, 0);

      // R2 readback
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, r); chk(r == 32'h1701, "R2 mode readback", r, 32'h1701);
      wr(8'h04, 32'hFF);        rd(8'h04, r); chk(r == 32'hF, "R2 length readback", r, 32'hF);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, r); chk(r == 32'h3F_FFFF, "R2 divider readback", r, 32'h3F_FFFF);
      wr(8'h54, 32'hFFFF);      rd(8'h54, r); chk(r == 32'h70B, "R2 pins readback", r, 32'h70B);
      rd(8'h0C, r); chk(r == 0, "R2 strobe reads zero", r, 0);
      rd(8'h34, r); chk(r == 0, "R2 tx data reads zero", r, 0);
      wr(8'h00, 0);

      // R12 pin routing
      wr(8'h54, 32'h50B);
      @(negedge clk);
      chk(sclk_oe && mosi_oe && pin_loc == 3'd5, "R12 pin outputs",
          {sclk_oe, mosi_oe, pin_loc}, {1'b1, 1'b1, 3'd5});

      // R10 R11 flags and lines
      rd(8'h40, r); chk(r == 32'h2, "R10 space flag after reset", r, 32'h2);
      wr(8'h4C, 32'h2); @(negedge clk);
      chk(irq_tx == 1 && irq_rx == 0, "R11 tx line enabled", {irq_tx, irq_rx}, 2'b10);
      wr(8'h48, 32'h2); rd(8'h40, r); chk(r == 32'h2, "R10 clear ignored while space", r, 32'h2);
      wr(8'h44, 32'h4); rd(8'h40, r); chk(r == 32'h6, "R10 software set", r, 32'h6);
      chk(irq_rx == 0, "R11 rx line masked", irq_rx, 0);
      wr(8'h4C, 32'h6); @(negedge clk);
      chk(irq_rx == 1, "R11 rx line enabled", irq_rx, 1);
      wr(8'h48, 32'h4); rd(8'h40, r); chk(r == 32'h2, "R10 software clear", r, 32'h2);
      wr(8'h4C, 0);

      // R3 start gating
      wr(8'h0C, 32'h15);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'd5); wr(8'h14, 0);
      m_cpha = 0; m_msbf = 0; exp_n = 8;
      mon_clear();
      wr(8'h34, 32'h3C);
      repeat (40) @(negedge clk);
      rd(8'h10, r);
      chk(tcount == 0 && r[6] == 0, "R3 no frame without sync bit", {tcount[15:0], r[15:0]}, 32'h0);
      chk(r[1] == 1, "R3 transmitter enable status", r, 32'h2);
      wr(8'h00, 32'h1);
      wait_done();
      chk(nwords == 1 && words[0] == 32'h3C, "R3 frame once allowed", words[0], 32'h3C);
      rd(8'h18, r);
      wr(8'h0C, 32'h08);
      mon_clear();
      wr(8'h34, 32'hC3);
      repeat (40) @(negedge clk);
      rd(8'h10, r);
      chk(tcount == 0 && r[1] == 0 && r[6] == 0, "R3 transmitter disabled", r, 32'h0);
      wr(8'h0C, 32'h04);
      wait_done();
      chk(nwords == 1 && words[0] == 32'hC3, "R3 frame after re-enable", words[0], 32'hC3);
      rd(8'h18, r);

      // directed modes and length clamps
      xfer(0, 0, 1, 5, 0,   32'hA5,   1);
      xfer(1, 1, 0, 5, 256, 32'h5A,   1);
      xfer(0, 1, 1, 0, 512, 32'hFFF9, 1);   // R4 low clamp
      xfer(1, 0, 0, 15, 128, 32'hBEEF, 1);  // R4 high clamp
      xfer(0, 0, 0, 13, 0, 32'h1234,  0);   // R9 receiver off

      // R12 data-in ignored when its pin is off
      wr(8'h54, 32'h50A);
      wr(8'h0C, 32'h15);
      setup(0, 0, 1, 5, 0);
      wr(8'h34, 32'hA5);
      wait_done();
      rd(8'h18, r); chk(r == 0, "R12 gated data-in reads zero", r, 0);
      wr(8'h54, 32'h50B);

      // R8 back-to-back and R9 overwrite
      wr(8'h0C, 32'h15);
      setup(0, 1, 1, 5, 768);
      a = 32'h81; b = 32'h7E;
      wr(8'h34, a);
      wr(8'h34, b);
      rd(8'h10, r);
      chk(r[6] == 0 && r[5] == 0, "R8 buffer occupied during frame", r, 32'h2);
      wait_done();
      chk(nwords == 2 && words[0] == a && words[1] == b, "R8 queued word follows",
          {words[0][15:0], words[1][15:0]}, {a[15:0], b[15:0]});
      chk(tcount == 32, "R8 two frames of transitions", tcount, 32);
      rd(8'h10, r); chk(r[6] == 1 && r[5] == 1, "R8 complete with empty buffer", r, 32'hE2);
      rd(8'h18, r); chk(r == b, "R9 newer frame overwrites", r, b);
      rd(8'h10, r); chk(r[7] == 0, "R9 read empties buffer", r, 0);

      // random mixes
      for (int i = 0; i < 20; i++) begin
         xfer($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 15), $urandom_range(0, 700), $urandom & 32'hFFFF, 1);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule